// File: doc/BRIEF.md
# Floating-Point Mode Register and Condition Flag Unit

This block holds the mode word and the three result flags of a pipelined floating-point data path. These flags are condition, zero and a sticky overflow status. A stage-1 port takes the miscellaneous-function instructions, which are function code zero plus a selector. Through that port the block loads the mode word from three instruction fields, clears the status flag, or returns the status on a data port. A stage-3 port takes the sign, zero and overflow indicators of each arithmetic result, together with that result's function code and condition-select field, and updates the flags.

In the following cycle, which is stage 4, the flags are driven onto three output pins. The exception pin's polarity comes from a mode bit. Because the pin is recomputed each cycle from the current mode word, a mode load that flips the polarity refreshes the pin at once. When a stage-3 update and a stage-1 operation fall in the same cycle, the stage-3 update is applied first and the stage-1 operation second.

Top module: `mode_flag_unit`

## Requirements
- R1: After reset the mode word is zero, `x_valid` is low, and `cond_pin`, `zero_pin` and `exc_pin` are all high. The status flag is clear.
- R2: A stage-1 instruction with function 0 and selector 3 loads the mode word on the next edge. The new value is `{3'b000, s1_abin, s1_cfld, s1_afld}`: the abin field goes in bits 12..10, the c field in bits 9..5 and the a field in bits 4..0.
- R3: A mode load whose new bit 5 (overflow exception enable) is clear also clears the status flag, overriding any stage-3 overflow in the same cycle. If the new bit 5 is set, the status keeps its stage-3 result.
- R4: A stage-1 instruction with function 0 and selector 0 clears the status flag, overriding any stage-3 overflow in the same cycle.
- R5: A stage-1 instruction with function 0 and selector 1 raises `x_valid` for one cycle, with `x_data` bit 0 equal to the status after that cycle's stage-3 update and all other bits zero.
- R6: A valid stage-3 entry with a nonzero function sets the condition flag from `s3_encn`: 1 gives result <= 0 (negative or zero), 2 gives result < 0 (negative and not zero), 3 gives result == 0, and 0 holds the flag.
- R7: For the same entries, an `s3_encn` of 1, 2 or 3 sets the zero flag to the zero indicator, and 0 holds it.
- R8: For the same entries, the status flag takes `s3_ovf` when mode bit 8 (exception active high) is set or the status is clear. Otherwise a set status stays set.
- R9: A stage-3 entry with `s3_valid` low or function 0 changes no flag.
- R10: `cond_pin` and `zero_pin` show the condition and zero flags one cycle after the flags change.
- R11: `exc_pin` equals the status when mode bit 8 is set and its inverse otherwise, one cycle behind the status and mode word. A mode load that changes bit 8 therefore refreshes the pin on the following edge.
- R12: A stage-1 instruction with a nonzero function, or with function 0 and selector 2 or 4..31, changes neither the mode word nor the status, and leaves `x_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s1_valid | input | 1 | Stage-1 instruction present |
| s1_func | input | 3 | Stage-1 function code |
| s1_sel | input | 5 | Stage-1 miscellaneous selector |
| s1_afld | input | 5 | Stage-1 a field (mode bits 4..0) |
| s1_cfld | input | 5 | Stage-1 c field (mode bits 9..5) |
| s1_abin | input | 3 | Stage-1 abin field (mode bits 12..10) |
| s3_valid | input | 1 | Stage-3 result present |
| s3_func | input | 3 | Function code of the stage-3 result |
| s3_encn | input | 2 | Condition select of the stage-3 result |
| s3_neg | input | 1 | Result is negative |
| s3_zero | input | 1 | Result is zero |
| s3_ovf | input | 1 | Result overflowed |
| mode_q | output | 16 | Current mode word |
| x_valid | output | 1 | Status read data valid |
| x_data | output | 32 | Status read data |
| cond_pin | output | 1 | Condition pin |
| zero_pin | output | 1 | Zero pin |
| exc_pin | output | 1 | Exception pin, polarity set by mode bit 8 |

## Verification
The assertions assume that every input is at a known level in each cycle after reset and that each port carries at most one entry per cycle. Beyond that they assume nothing about the inputs. The sign and zero indicators may arrive in any combination, including negative zero. The stimulus therefore draws every field freely and only weights the stage-1 selector towards the three defined operations. Directed sequences then set up sticky overflow, a same-cycle clash between a clear and an overflow, and flips of the pin polarity.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  localparam int FN_W  = 3;
  localparam int SEL_W = 5;
  localparam int AF_W  = 5;
  localparam int CF_W  = 5;
  localparam int AB_W  = 3;
  localparam int EN_W  = 2;
  localparam int PACK_W = AB_W + CF_W + AF_W;

  localparam int MB_OVF_EN = 5;
  localparam int MB_HI     = 8;

  localparam logic [SEL_W-1:0] SEL_CLR  = 5'd0;
  localparam logic [SEL_W-1:0] SEL_RD   = 5'd1;
  localparam logic [SEL_W-1:0] SEL_MODE = 5'd3;

  typedef enum logic [EN_W-1:0] {
    CS_HOLD = 2'd0,
    CS_LE   = 2'd1,
    CS_LT   = 2'd2,
    CS_EQ   = 2'd3
  } csel_e;

  function automatic logic cond_eval(input csel_e sel, input logic neg,
                                     input logic zero, input logic cur);
    case (sel)
      CS_LE:   return neg | zero;
      CS_LT:   return neg & ~zero;
      CS_EQ:   return zero;
      default: return cur;
    endcase
  endfunction

  function automatic logic [PACK_W-1:0] mode_pack(input logic [AB_W-1:0] ab,
                                                  input logic [CF_W-1:0] cf,
                                                  input logic [AF_W-1:0] af);
    return {ab, cf, af};
  endfunction

  function automatic logic exc_level(input logic hi, input logic st);
    return hi ? st : ~st;
  endfunction
endpackage

// File: rtl/mfu_mode_ctl.sv
module mfu_mode_ctl
  import mfu_pkg::*;
#(
  parameter int MW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [FN_W-1:0]  s1_func,
  input  logic [SEL_W-1:0] s1_sel,
  input  logic [AF_W-1:0]  s1_afld,
  input  logic [CF_W-1:0]  s1_cfld,
  input  logic [AB_W-1:0]  s1_abin,
  output logic [MW-1:0]    mode_q,
  output logic             clr_req,
  output logic             rd_req
);
  logic           misc;
  logic           mode_ld;
  logic [MW-1:0]  mode_nx;

  assign misc    = s1_valid && (s1_func == '0);
  assign mode_ld = misc && (s1_sel == SEL_MODE);
  assign rd_req  = misc && (s1_sel == SEL_RD);
  assign mode_nx = MW'(mode_pack(s1_abin, s1_cfld, s1_afld));
  assign clr_req = (misc && (s1_sel == SEL_CLR)) || (mode_ld && !mode_nx[MB_OVF_EN]);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ld) mode_q <= mode_nx;
  end

  // R2: a load shows its fields on the next edge
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> mode_q[PACK_W-1:0] == {$past(s1_abin), $past(s1_cfld), $past(s1_afld)});
  // R12: without a load the mode word holds
  a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> $stable(mode_q));
endmodule

// File: rtl/mfu_flags.sv
module mfu_flags
  import mfu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s3_valid,
  input  logic [FN_W-1:0] s3_func,
  input  logic [EN_W-1:0] s3_encn,
  input  logic            s3_neg,
  input  logic            s3_zero,
  input  logic            s3_ovf,
  input  logic            mode_hi,
  input  logic            clr_req,
  output logic            cr_q,
  output logic            zr_q,
  output logic            sr_q,
  output logic            sr_s3
);
  logic  s3_upd;
  csel_e csel;

  assign s3_upd = s3_valid && (s3_func != '0);
  assign csel   = csel_e'(s3_encn);
  assign sr_s3  = (s3_upd && (mode_hi || !sr_q)) ? s3_ovf : sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q <= 1'b1;
      zr_q <= 1'b1;
      sr_q <= 1'b0;
    end else begin
      if (s3_upd) begin
        cr_q <= cond_eval(csel, s3_neg, s3_zero, cr_q);
        if (csel != CS_HOLD) zr_q <= s3_zero;
      end
      sr_q <= clr_req ? 1'b0 : sr_s3;
    end
  end

  // R4 / R3: a clear request always wins
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !sr_q);
  // R8: sticky status while polarity bit low
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q && !mode_hi && !clr_req) |=> sr_q);
  // R9: no stage-3 update leaves condition and zero flags alone
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_upd |=> ($stable(cr_q) && $stable(zr_q)));
  // R7: zero flag follows the indicator on a selecting entry
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_upd && s3_encn != 2'd0) |=> (zr_q == $past(s3_zero)));
endmodule

// File: rtl/mfu_pins.sv
module mfu_pins
  import mfu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cr,
  input  logic zr,
  input  logic sr,
  input  logic mode_hi,
  output logic cond_pin,
  output logic zero_pin,
  output logic exc_pin
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_pin <= 1'b1;
      zero_pin <= 1'b1;
      exc_pin  <= 1'b1;
    end else begin
      cond_pin <= cr;
      zero_pin <= zr;
      exc_pin  <= exc_level(mode_hi, sr);
    end
  end

  // R10: a rising condition flag reaches the pin one cycle later
  a_r10_cond_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr) |=> cond_pin);
  // R11: active-low polarity shows a set status as a low pin
  a_r11_low_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && !mode_hi) |=> !exc_pin);
  a_r11_high_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && mode_hi) |=> exc_pin);
endmodule

// File: rtl/mode_flag_unit.sv
module mode_flag_unit
  import mfu_pkg::*;
#(
  parameter int MW = 16,
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  logic [2:0]    s1_func,
  input  logic [4:0]    s1_sel,
  input  logic [4:0]    s1_afld,
  input  logic [4:0]    s1_cfld,
  input  logic [2:0]    s1_abin,
  input  logic          s3_valid,
  input  logic [2:0]    s3_func,
  input  logic [1:0]    s3_encn,
  input  logic          s3_neg,
  input  logic          s3_zero,
  input  logic          s3_ovf,
  output logic [MW-1:0] mode_q,
  output logic          x_valid,
  output logic [XW-1:0] x_data,
  output logic          cond_pin,
  output logic          zero_pin,
  output logic          exc_pin
);
  logic clr_req, rd_req;
  logic cr_q, zr_q, sr_q, sr_s3;
  logic mode_hi;

  assign mode_hi = mode_q[MB_HI];

  mfu_mode_ctl #(.MW(MW)) u_mode (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_func(s1_func),
    .s1_sel(s1_sel), .s1_afld(s1_afld), .s1_cfld(s1_cfld), .s1_abin(s1_abin),
    .mode_q(mode_q), .clr_req(clr_req), .rd_req(rd_req)
  );

  mfu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .s3_valid(s3_valid), .s3_func(s3_func),
    .s3_encn(s3_encn), .s3_neg(s3_neg), .s3_zero(s3_zero), .s3_ovf(s3_ovf),
    .mode_hi(mode_hi), .clr_req(clr_req),
    .cr_q(cr_q), .zr_q(zr_q), .sr_q(sr_q), .sr_s3(sr_s3)
  );

  mfu_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cr(cr_q), .zr(zr_q), .sr(sr_q),
    .mode_hi(mode_hi), .cond_pin(cond_pin), .zero_pin(zero_pin), .exc_pin(exc_pin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_valid <= 1'b0;
      x_data  <= '0;
    end else begin
      x_valid <= rd_req;
      if (rd_req) x_data <= XW'(sr_s3);
    end
  end

  // R5: a read produces exactly one valid cycle
  a_r5_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> x_valid);
  a_r12_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !x_valid);
  // R5: read data carries only the status bit
  a_r5_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid |-> (x_data[XW-1:1] == '0));
endmodule

// File: tb/sim_mode_flag_unit.sv
module sim_mode_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s1_valid = 1'b0;
  logic [2:0]  s1_func = '0;
  logic [4:0]  s1_sel = '0, s1_afld = '0, s1_cfld = '0;
  logic [2:0]  s1_abin = '0;
  logic        s3_valid = 1'b0;
  logic [2:0]  s3_func = '0;
  logic [1:0]  s3_encn = '0;
  logic        s3_neg = 1'b0, s3_zero = 1'b0, s3_ovf = 1'b0;
  logic [15:0] mode_q;
  logic        x_valid;
  logic [31:0] x_data;
  logic        cond_pin, zero_pin, exc_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic [15:0] m_mode;
  logic m_cr, m_zr, m_sr, m_pc, m_pz, m_pe, m_xv, m_xd;

  always #5 clk = ~clk;

  mode_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_func(s1_func),
    .s1_sel(s1_sel), .s1_afld(s1_afld), .s1_cfld(s1_cfld), .s1_abin(s1_abin),
    .s3_valid(s3_valid), .s3_func(s3_func), .s3_encn(s3_encn),
    .s3_neg(s3_neg), .s3_zero(s3_zero), .s3_ovf(s3_ovf),
    .mode_q(mode_q), .x_valid(x_valid), .x_data(x_data),
    .cond_pin(cond_pin), .zero_pin(zero_pin), .exc_pin(exc_pin)
  );

  function automatic logic ref_cond(logic [1:0] e, logic ng, logic zz, logic cur);
    if (e == 2'd1) return (ng || zz);
    if (e == 2'd2) return (ng && !zz);
    if (e == 2'd3) return zz;
    return cur;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one edge and update the model from the driven inputs
  task automatic step();
    logic sr3;
    logic [15:0] nm;
    @(posedge clk);
    m_pc = m_cr;
    m_pz = m_zr;
    m_pe = m_mode[8] ? m_sr : !m_sr;
    sr3 = m_sr;
    if (s3_valid && s3_func != 3'd0) begin
      if (m_mode[8] || !m_sr) sr3 = s3_ovf;
      m_cr = ref_cond(s3_encn, s3_neg, s3_zero, m_cr);
      if (s3_encn != 2'd0) m_zr = s3_zero;
    end
    m_sr = sr3;
    m_xv = 1'b0;
    if (s1_valid && s1_func == 3'd0) begin
      if (s1_sel == 5'd0) m_sr = 1'b0;
      else if (s1_sel == 5'd1) begin m_xv = 1'b1; m_xd = sr3; end
      else if (s1_sel == 5'd3) begin
        nm = {3'b000, s1_abin, s1_cfld, s1_afld};
        m_mode = nm;
        if (!nm[5]) m_sr = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic compare(input string tag);
    check(mode_q == m_mode, {tag, "/R2 mode"}, 32'(mode_q), 32'(m_mode));
    check(cond_pin == m_pc, {tag, "/R6 R10 cond_pin"}, 32'(cond_pin), 32'(m_pc));
    check(zero_pin == m_pz, {tag, "/R7 R10 zero_pin"}, 32'(zero_pin), 32'(m_pz));
    check(exc_pin == m_pe, {tag, "/R8 R11 exc_pin"}, 32'(exc_pin), 32'(m_pe));
    check(x_valid == m_xv, {tag, "/R5 R12 x_valid"}, 32'(x_valid), 32'(m_xv));
    if (m_xv)
      check(x_data == 32'(m_xd), {tag, "/R5 x_data"}, x_data, 32'(m_xd));
  endtask

  task automatic idle();
    s1_valid = 0; s3_valid = 0;
  endtask

  task automatic s1(input logic [2:0] f, input logic [4:0] sel,
                    input logic [2:0] ab, input logic [4:0] cf, input logic [4:0] af);
    s1_valid = 1; s1_func = f; s1_sel = sel; s1_abin = ab; s1_cfld = cf; s1_afld = af;
  endtask

  task automatic s3(input logic [2:0] f, input logic [1:0] e,
                    input logic ng, input logic zz, input logic ov);
    s3_valid = 1; s3_func = f; s3_encn = e; s3_neg = ng; s3_zero = zz; s3_ovf = ov;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_mode = '0; m_cr = 1; m_zr = 1; m_sr = 0;
    m_pc = 1; m_pz = 1; m_pe = 1; m_xv = 0; m_xd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(mode_q == 16'h0, "R1 mode", 32'(mode_q), 0);
    check({cond_pin, zero_pin, exc_pin} == 3'b111, "R1 pins",
          32'({cond_pin, zero_pin, exc_pin}), 7);
    check(!x_valid, "R1 x_valid", 32'(x_valid), 0);
    s1(3'd0, 5'd1, 0, 0, 0); step(); idle(); compare("R1 read");

    // R8 sticky: overflow sets status, later no-overflow keeps it
    s3(3'd3, 2'd0, 0, 0, 1); step(); idle(); compare("R8 set");
    s3(3'd3, 2'd0, 0, 0, 0); step(); idle(); compare("R8 hold");
    step(); compare("R8 pin");
    // R9: func 0 stage-3 entry changes nothing
    s3(3'd0, 2'd1, 1, 1, 0); step(); idle(); compare("R9 func0");
    step(); compare("R9 after");
    // R4: clear wins over same-cycle overflow
    s1(3'd0, 5'd0, 0, 0, 0); s3(3'd2, 2'd3, 0, 1, 1); step(); idle(); compare("R4 clr");
    s1(3'd0, 5'd1, 0, 0, 0); step(); idle(); compare("R4 read");
    // R11: set active high (bit 8 -> cfld bit3) with overflow enable (bit 5 -> cfld bit0)
    s1(3'd0, 5'd3, 0, 5'b01001, 0); step(); idle(); compare("R11 hi");
    step(); compare("R11 pin hi");
    // R8: with active-high status follows overflow both ways
    s3(3'd7, 2'd2, 1, 0, 1); step(); idle(); compare("R8 hi set");
    s3(3'd7, 2'd1, 0, 1, 0); step(); idle(); compare("R8 hi drop");
    s3(3'd5, 2'd2, 1, 0, 1); step(); idle(); compare("R8 hi set2");
    // R11: flip polarity back, keep overflow enable: pin inverts
    s1(3'd0, 5'd3, 0, 5'b00001, 0); step(); idle(); compare("R11 flip");
    step(); compare("R11 pin lo");
    // R3: load with overflow enable clear clears status even with overflow
    s1(3'd0, 5'd3, 3'd7, 5'b10110, 5'd31); s3(3'd1, 2'd0, 0, 0, 1); step(); idle();
    compare("R3 mode clr");
    s1(3'd0, 5'd1, 0, 0, 0); step(); idle(); compare("R3 read");
    // R12: unused selectors and nonzero func
    s1(3'd0, 5'd2, 7, 31, 31); step(); idle(); compare("R12 sel2");
    s1(3'd4, 5'd3, 7, 31, 31); step(); idle(); compare("R12 func");
    // R6: negative zero under each select
    s3(3'd2, 2'd2, 1, 1, 0); step(); idle(); compare("R6 lt negzero");
    s3(3'd2, 2'd1, 1, 1, 0); step(); idle(); compare("R6 le negzero");
    step(); compare("R6 pin");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      s1_valid = $urandom_range(0, 1);
      s1_func  = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
      r = $urandom_range(0, 9);
      s1_sel = (r < 3) ? 5'd3 : (r < 5) ? 5'd0 : (r < 7) ? 5'd1 : 5'($urandom);
      s1_abin = 3'($urandom); s1_cfld = 5'($urandom); s1_afld = 5'($urandom);
      s3_valid = $urandom_range(0, 1);
      s3_func = 3'($urandom); s3_encn = 2'($urandom);
      s3_neg = 1'($urandom); s3_zero = 1'($urandom); s3_ovf = 1'($urandom);
      step();
      compare("RND R6 R7 R8 R9");
    end
    idle(); step(); compare("end");

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule